// File: doc/BRIEF.md
# Bit-Skipping Adder with Condition Codes

This block is a 16-bit adder with a negative/zero/positive condition-code stage. It is built so that a datapath with one permanently broken bit position can keep running as a 15-bit machine. A static one-hot configuration word, `dead_mask`, names the broken position. The adder then routes its carry around that position. The dead position's sum bit is held at zero. The condition flags read only the live positions.

With an all-zero mask the block is a plain 16-bit adder with carry-in and carry-out. A mask with more than one bit set cannot describe a single defect. In that case the block raises `cfg_err` and behaves as if no bit were dead. Choosing the broken position is left to the surrounding system.

Top module: `fault_skip_adder`

## Requirements
- R1: With `dead_mask` all zero, `{carry_out, sum}` equals `op_a + op_b + carry_in` over 17 bits.
- R2: With position k dead, the carry that leaves position k-1 enters position k+1. When k is 0, `carry_in` enters position 1 directly.
- R3: With position 15 dead, `carry_out` is the carry that leaves position 14.
- R4: The `sum` bit at the dead position is always 0.
- R5: With position k dead, the 15 live bits of `sum` and `carry_out` match the following steps. Pack the live bits of each operand into 15-bit numbers. Add them with `carry_in`. Unpack the 15-bit result into the live positions. `carry_out` is bit 15 of that addition.
- R6: `flag_n` is `sum[15]`, or `sum[14]` when position 15 is dead.
- R7: `flag_z` is 1 exactly when every live bit of `sum` is 0.
- R8: `flag_p` is 1 exactly when both `flag_n` and `flag_z` are 0. Exactly one of the three flags is 1.
- R9: A `dead_mask` with two or more bits set drives `cfg_err` to 1, and all outputs then follow R1. A mask that is zero or one-hot drives `cfg_err` to 0.
- R10: The operand bits at the dead position have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| carry_in | input | 1 | Carry into the lowest live position |
| dead_mask | input | 16 | Static mask; bit k set means position k is unusable |
| sum | output | 16 | Result, with a zero at the dead position |
| carry_out | output | 1 | Carry out of the highest live position |
| flag_n | output | 1 | Result is negative (top live bit) |
| flag_z | output | 1 | All live result bits are zero |
| flag_p | output | 1 | Result is neither negative nor zero |
| cfg_err | output | 1 | Mask has more than one bit set |

## Verification
The hardest case to reach is a carry that must jump the dead position. This needs a run of live ones that ends exactly at k-1 and is followed by a live bit at k+1, and random operands seldom produce it.

The directed vectors build that run on purpose. Examples are bit 4 dead with the low four bits all ones, bit 0 dead with only `carry_in` set, and a carry that wraps across every live bit. A sweep then covers every dead position with pseudo-random operands, compared against a pack-add-unpack model. At each dead position the bench also flips the dead operand bits to show they change nothing.

// File: rtl/fsa_pkg.sv
package fsa_pkg;

    localparam int DATA_W = 16;

    typedef struct packed {
        logic neg;
        logic zero;
        logic pos;
    } cc_flags_t;

    function automatic logic maj3(input logic x, input logic y, input logic z);
        return (x & y) | (x & z) | (y & z);
    endfunction

endpackage

// File: rtl/fsa_mask_guard.sv
module fsa_mask_guard #(
    parameter int W = fsa_pkg::DATA_W
) (
    input  logic [W-1:0] raw_mask,
    output logic [W-1:0] dead,
    output logic         cfg_err
);
    logic multi;

    // Clearing the lowest set bit leaves a nonzero value only if two or more bits were set.
    assign multi   = |(raw_mask & (raw_mask - W'(1)));
    assign cfg_err = multi;
    assign dead    = multi ? '0 : raw_mask;

    always_comb begin
        if (cfg_err) assert_fallback_R9: assert (dead == '0);
    end
endmodule

// File: rtl/fsa_skip_chain.sv
module fsa_skip_chain #(
    parameter int W = fsa_pkg::DATA_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic [W-1:0] dead,
    output logic [W-1:0] sum,
    output logic         cout
);
    // chain[i] is the carry arriving at position i.
    logic [W:0] chain;
    assign chain[0] = cin;

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic raw_sum, raw_carry;
        assign raw_sum      = a[i] ^ b[i] ^ chain[i];
        assign raw_carry    = fsa_pkg::maj3(a[i], b[i], chain[i]);
        // A dead position passes its incoming carry straight through and outputs zero.
        assign sum[i]       = dead[i] ? 1'b0 : raw_sum;
        assign chain[i+1]   = dead[i] ? chain[i] : raw_carry;
    end

    assign cout = chain[W];
endmodule

// File: rtl/fsa_cc_unit.sv
module fsa_cc_unit #(
    parameter int W = fsa_pkg::DATA_W
) (
    input  logic [W-1:0]       result,
    input  logic [W-1:0]       dead,
    output fsa_pkg::cc_flags_t flags
);
    logic sign_bit, all_zero;

    assign sign_bit   = dead[W-1] ? result[W-2] : result[W-1];
    assign all_zero   = ~|(result & ~dead);
    assign flags.neg  = sign_bit;
    assign flags.zero = all_zero;
    assign flags.pos  = ~sign_bit & ~all_zero;

    always_comb begin
        assert_single_flag_R8: assert ($onehot({flags.neg, flags.zero, flags.pos}));
    end
endmodule

// File: rtl/fault_skip_adder.sv
module fault_skip_adder #(
    parameter int WIDTH = fsa_pkg::DATA_W
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             carry_in,
    input  logic [WIDTH-1:0] dead_mask,
    output logic [WIDTH-1:0] sum,
    output logic             carry_out,
    output logic             flag_n,
    output logic             flag_z,
    output logic             flag_p,
    output logic             cfg_err
);
    localparam int XW = WIDTH + 1;

    logic [WIDTH-1:0]   dead_eff;
    fsa_pkg::cc_flags_t cc;

    fsa_mask_guard #(.W(WIDTH)) u_guard (
        .raw_mask (dead_mask),
        .dead     (dead_eff),
        .cfg_err  (cfg_err)
    );

    fsa_skip_chain #(.W(WIDTH)) u_chain (
        .a    (op_a),
        .b    (op_b),
        .cin  (carry_in),
        .dead (dead_eff),
        .sum  (sum),
        .cout (carry_out)
    );

    fsa_cc_unit #(.W(WIDTH)) u_cc (
        .result (sum),
        .dead   (dead_eff),
        .flags  (cc)
    );

    assign flag_n = cc.neg;
    assign flag_z = cc.zero;
    assign flag_p = cc.pos;

    always_comb begin
        assert_dead_bit_low_R4: assert ((sum & dead_eff) == '0);
        assert_mask_single_R9:  assert ($countones(dead_eff) <= 1);
        if (dead_eff == '0)
            assert_plain_add_R1: assert ({carry_out, sum} ==
                ({1'b0, op_a} + {1'b0, op_b} + XW'(carry_in)));
    end
endmodule

// File: tb/tb_fault_skip_adder.sv
module tb_fault_skip_adder;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 10;

    typedef struct packed {
        logic [15:0] a;
        logic [15:0] b;
        logic [15:0] m;
        logic        cin;
        logic [15:0] s;
        logic        co;
        logic [2:0]  nzp;
        logic        err;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{16'h1234, 16'h1111, 16'h0000, 1'b0, 16'h2345, 1'b0, 3'b001, 1'b0},
        '{16'h0001, 16'hFFFF, 16'h0000, 1'b0, 16'h0000, 1'b1, 3'b010, 1'b0},
        '{16'h0002, 16'h0002, 16'h0001, 1'b0, 16'h0004, 1'b0, 3'b001, 1'b0},
        '{16'h7FFF, 16'h0001, 16'h8000, 1'b0, 16'h0000, 1'b1, 3'b010, 1'b0},
        '{16'h0000, 16'h0000, 16'h0001, 1'b1, 16'h0002, 1'b0, 3'b001, 1'b0},
        '{16'h4000, 16'h0000, 16'h8000, 1'b0, 16'h4000, 1'b0, 3'b100, 1'b0},
        '{16'h000F, 16'h0001, 16'h0010, 1'b0, 16'h0020, 1'b0, 3'b001, 1'b0},
        '{16'hFFFF, 16'h0001, 16'h0003, 1'b0, 16'h0000, 1'b1, 3'b010, 1'b1},
        '{16'hFFFF, 16'h0000, 16'h0010, 1'b1, 16'h0000, 1'b1, 3'b010, 1'b0},
        '{16'h8000, 16'h0000, 16'h0000, 1'b0, 16'h8000, 1'b0, 3'b100, 1'b0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [15:0] op_a = '0, op_b = '0, dead_mask = '0;
    logic carry_in = 1'b0;
    logic [15:0] sum;
    logic carry_out, flag_n, flag_z, flag_p, cfg_err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [31:0] lfsr = 32'hACE1_2468;

    fault_skip_adder dut (
        .op_a(op_a), .op_b(op_b), .carry_in(carry_in), .dead_mask(dead_mask),
        .sum(sum), .carry_out(carry_out), .flag_n(flag_n), .flag_z(flag_z),
        .flag_p(flag_p), .cfg_err(cfg_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [31:0] next_rand(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    // Model: {nzp, err, cout, sum}. Builds the result by packing, adding and unpacking the live bits.
    function automatic logic [20:0] model(input logic [15:0] a, input logic [15:0] b,
                                          input logic [15:0] m, input logic cin);
        logic [15:0] em, pa, pb, ps, out;
        logic legal, co, n, z;
        int j;
        legal = ((m & (m - 16'd1)) == 16'd0);
        em = legal ? m : 16'd0;
        if (em == 16'd0) begin
            {co, out} = {1'b0, a} + {1'b0, b} + {16'd0, cin};
        end else begin
            pa = '0; pb = '0; j = 0;
            for (int i = 0; i < 16; i++)
                if (!em[i]) begin pa[j] = a[i]; pb[j] = b[i]; j++; end
            ps = pa + pb + {15'd0, cin};
            co = ps[15];
            out = '0; j = 0;
            for (int i = 0; i < 16; i++)
                if (!em[i]) begin out[i] = ps[j]; j++; end
        end
        n = em[15] ? out[14] : out[15];
        z = ((out & ~em) == 16'd0);
        return {n, z, ~n & ~z, ~legal, co, out};
    endfunction

    task automatic check(input logic ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic [15:0] a, input logic [15:0] b,
                         input logic [15:0] m, input logic cin);
        @(posedge clk);
        op_a = a; op_b = b; dead_mask = m; carry_in = cin;
        @(negedge clk);
    endtask

    task automatic check_model(input string req);
        logic [20:0] exp;
        exp = model(op_a, op_b, dead_mask, carry_in);
        check({flag_n, flag_z, flag_p, cfg_err, carry_out, sum} == exp, req, "outputs vs model",
              {11'd0, flag_n, flag_z, flag_p, cfg_err, carry_out, sum}, {11'd0, exp});
    endtask

    initial begin
        logic [20:0] base;
        logic [15:0] ra, rb, mk;
        repeat (2) @(posedge clk);
        rst = 1'b0;

        // All-zero inputs after reset: plain adder, zero result (R1, R7)
        @(negedge clk);
        check(sum == 16'd0 && carry_out == 1'b0, "R1", "idle sum", {15'd0, carry_out, sum}, 32'd0);
        check({flag_n, flag_z, flag_p} == 3'b010 && cfg_err == 1'b0, "R7", "idle flags",
              {28'd0, flag_n, flag_z, flag_p, cfg_err}, 32'h4);

        // Directed vectors (R1 R2 R3 R4 R6 R7 R8 R9)
        for (int v = 0; v < NV; v++) begin
            apply(VECS[v].a, VECS[v].b, VECS[v].m, VECS[v].cin);
            check(sum == VECS[v].s, "R2", "vector sum", {16'd0, sum}, {16'd0, VECS[v].s});
            check(carry_out == VECS[v].co, "R3", "vector carry", {31'd0, carry_out}, {31'd0, VECS[v].co});
            check({flag_n, flag_z, flag_p} == VECS[v].nzp, "R6", "vector flags",
                  {29'd0, flag_n, flag_z, flag_p}, {29'd0, VECS[v].nzp});
            check(cfg_err == VECS[v].err, "R9", "vector cfg_err", {31'd0, cfg_err}, {31'd0, VECS[v].err});
        end

        // Sweep every dead position (and none) against the pack-add-unpack model (R5),
        // and show that the dead operand bits change nothing (R10).
        for (int k = -1; k < 16; k++) begin
            mk = (k < 0) ? 16'd0 : (16'd1 << k);
            for (int t = 0; t < 40; t++) begin
                lfsr = next_rand(lfsr); ra = lfsr[15:0]; rb = lfsr[31:16];
                lfsr = next_rand(lfsr);
                apply(ra, rb, mk, lfsr[0]);
                check_model("R5");
                check((sum & mk) == 16'd0, "R4", "dead sum bit", {16'd0, sum & mk}, 32'd0);
                if (k >= 0) begin
                    base = {flag_n, flag_z, flag_p, cfg_err, carry_out, sum};
                    apply(ra ^ mk, rb ^ (lfsr[1] ? mk : 16'd0), mk, op_a == ra ? carry_in : carry_in);
                    check({flag_n, flag_z, flag_p, cfg_err, carry_out, sum} == base, "R10",
                          "dead operand bits ignored",
                          {11'd0, flag_n, flag_z, flag_p, cfg_err, carry_out, sum}, {11'd0, base});
                end
            end
        end

        // Illegal masks fall back to a full-width add (R9)
        for (int t = 0; t < 20; t++) begin
            lfsr = next_rand(lfsr);
            mk = lfsr[15:0] | 16'h0101;
            lfsr = next_rand(lfsr);
            apply(lfsr[15:0], lfsr[31:16], mk, lfsr[3]);
            check(cfg_err == 1'b1, "R9", "multi-bit mask flagged", {31'd0, cfg_err}, 32'd1);
            check({carry_out, sum} == {1'b0, op_a} + {1'b0, op_b} + {16'd0, carry_in}, "R9",
                  "fallback add", {15'd0, carry_out, sum},
                  {15'd0, {1'b0, op_a} + {1'b0, op_b} + {16'd0, carry_in}});
        end

        // Bit 0 dead: carry_in reaches bit 1 through the skip (R2)
        apply(16'h0001, 16'h0001, 16'h0001, 1'b1);
        check(sum == 16'h0002 && carry_out == 1'b0, "R2", "cin skips dead bit 0",
              {15'd0, carry_out, sum}, 32'h0002);

        // Bit 15 dead: negative sign read from bit 14 (R6), carry out from bit 14 (R3)
        apply(16'h4000, 16'h4000, 16'h8000, 1'b0);
        check(sum == 16'h0000 && carry_out == 1'b1, "R3", "carry out of bit 14",
              {15'd0, carry_out, sum}, 32'h10000);
        check({flag_n, flag_z, flag_p} == 3'b010, "R8", "zero after wrap",
              {29'd0, flag_n, flag_z, flag_p}, 32'h2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule